// File: doc/BRIEF.md
# Test-and-Set Lock Requester with Doubling Backoff

This block sits between one local agent and a shared lock memory. The memory holds a single lock word and is reached through an arbiter. The agent sends a one-cycle acquire command. The block then polls the lock word with plain reads for as long as the word reads nonzero. Once a read returns zero, it issues one atomic test-and-set, which returns the old value and leaves a 1 in the lock word. An old value of zero means the lock now belongs to this requester: the block pulses `granted` for one cycle and raises `holding`. A nonzero old value means another requester won the race. In that case the block waits out a backoff interval before it polls again. The interval starts at one cycle and doubles after every failed attempt, up to `MAX_BACKOFF`. A one-cycle release command from the holder sends a plain write of zero to the lock word.

The state machine has eight named states. IDLE waits for an acquire. POLL requests a read and POLL_WAIT waits for its data. A nonzero read goes back to POLL, and a zero read goes on to TAS. TAS requests the atomic operation and TAS_WAIT waits for the old value. A zero old value goes to HELD, and a nonzero one goes to BACKOFF. BACKOFF returns to POLL when its timer expires. HELD moves to RELEASE on a release command. RELEASE requests the write and returns to IDLE when it is granted.

Memory requests use a req/gnt handshake: the request and its opcode stay up until `mem_gnt` is seen. Reads and test-and-set return data with a one-cycle `mem_rvalid` pulse. Writes finish at the grant and return nothing.

Top module: `tas_lock_requester`

## Requirements
- R1: After reset, `mem_req`, `granted` and `holding` are low, and the backoff interval is 1 cycle.
- R2: An acquire command in IDLE starts a read of the lock word (`mem_op` = 2'b00 read; 2'b01 write; 2'b10 test-and-set).
- R3: While reads return a nonzero lock value, the block issues only further reads and never a test-and-set.
- R4: A read that returns zero is followed by exactly one test-and-set request.
- R5: A test-and-set whose old value is zero raises `granted` for exactly one cycle and sets `holding`, both in the cycle after the response.
- R6: A test-and-set whose old value is nonzero holds `mem_req` low for B cycles after the response cycle, where B is the current interval. The next read request comes in the cycle after those B cycles.
- R7: The interval starts at 1, doubles after every failed test-and-set, and saturates at `MAX_BACKOFF`.
- R8: A successful acquire resets the interval to 1 for the next acquire.
- R9: A release command while holding issues a write of zero to the lock word, drops `holding` and returns to IDLE.
- R10: A release command while not holding, and an acquire command while not in IDLE, cause no memory request and no state change.
- R11: A pending request keeps `mem_req` and `mem_op` stable until it is granted.
- R12: When several requesters share the lock through a round-robin arbiter, at most one holds it at any time, and every acquire is eventually granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_cmd | input | 1 | One-cycle acquire command from the local agent |
| rel_cmd | input | 1 | One-cycle release command from the local agent |
| granted | output | 1 | One-cycle pulse when the lock has been won |
| holding | output | 1 | High while this requester owns the lock |
| mem_req | output | 1 | Memory request, held until granted |
| mem_op | output | 2 | Request opcode: 00 read, 01 write, 10 test-and-set |
| mem_wdata | output | DATA_W | Write data (zero for a release) |
| mem_gnt | input | 1 | Arbiter grant for the current request |
| mem_rvalid | input | 1 | One-cycle pulse that marks returned data |
| mem_rdata | input | DATA_W | Read data or old value from test-and-set |

## Verification
On every cycle, the assertions check the handshake stability, the single-cycle width of the grant pulse, the write that follows a release, the quiet request line after a failed attempt, and the range and reset value of the backoff interval. Other behaviours only show up across whole scenarios. The bench runs a sweep of forced test-and-set failures and measures the exact gap before each new poll, which covers doubling and saturation. It also confirms that reads alone are issued while the lock is taken. Finally, three requesters contend through a round-robin arbiter, and the bench shows that ownership stays exclusive and that every acquire completes.

// File: rtl/tasl_pkg.sv
package tasl_pkg;

    typedef enum logic [1:0] {
        MEM_RD  = 2'b00,
        MEM_WR  = 2'b01,
        MEM_TAS = 2'b10
    } mem_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_POLL,
        ST_POLL_WAIT,
        ST_TAS,
        ST_TAS_WAIT,
        ST_BACKOFF,
        ST_HELD,
        ST_RELEASE
    } lock_state_e;

endpackage

// File: rtl/tasl_backoff.sv
module tasl_backoff #(
    parameter int MAX_BACKOFF = 64,
    localparam int CW = $clog2(MAX_BACKOFF + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic clear_i,
    output logic expire_o
);

    localparam logic [CW-1:0] MAXV = CW'(MAX_BACKOFF);

    logic [CW-1:0] interval_q;
    logic [CW-1:0] count_q;
    logic [CW:0]   doubled;
    logic [CW-1:0] next_interval;

    always_comb begin
        doubled = {interval_q, 1'b0};
        if (doubled > {1'b0, MAXV}) begin
            next_interval = MAXV;
        end else begin
            next_interval = doubled[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            interval_q <= CW'(1);
            count_q    <= '0;
        end else if (arm_i) begin
            count_q    <= interval_q;
            interval_q <= next_interval;
        end else begin
            if (clear_i) begin
                interval_q <= CW'(1);
            end
            if (count_q != '0) begin
                count_q <= count_q - CW'(1);
            end
        end
    end

    assign expire_o = (count_q == CW'(1));

    p_interval_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (interval_q != '0) && (interval_q <= MAXV));

    p_interval_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i && !arm_i) |=> (interval_q == CW'(1)));

endmodule

// File: rtl/tasl_ctrl.sv
module tasl_ctrl
    import tasl_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    acq_cmd_i,
    input  logic    rel_cmd_i,
    input  logic    mem_gnt_i,
    input  logic    mem_rvalid_i,
    input  logic    rd_nonzero_i,
    input  logic    bo_expire_i,
    output logic    mem_req_o,
    output mem_op_e mem_op_o,
    output logic    bo_arm_o,
    output logic    bo_clear_o,
    output logic    granted_o,
    output logic    holding_o
);

    lock_state_e state_q, state_d;
    logic        grant_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:      if (acq_cmd_i)    state_d = ST_POLL;
            ST_POLL:      if (mem_gnt_i)    state_d = ST_POLL_WAIT;
            ST_POLL_WAIT: if (mem_rvalid_i) state_d = rd_nonzero_i ? ST_POLL : ST_TAS;
            ST_TAS:       if (mem_gnt_i)    state_d = ST_TAS_WAIT;
            ST_TAS_WAIT:  if (mem_rvalid_i) state_d = rd_nonzero_i ? ST_BACKOFF : ST_HELD;
            ST_BACKOFF:   if (bo_expire_i)  state_d = ST_POLL;
            ST_HELD:      if (rel_cmd_i)    state_d = ST_RELEASE;
            ST_RELEASE:   if (mem_gnt_i)    state_d = ST_IDLE;
            default:                        state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            grant_q <= 1'b0;
        end else begin
            state_q <= state_d;
            grant_q <= (state_d == ST_HELD) && (state_q != ST_HELD);
        end
    end

    always_comb begin
        mem_req_o  = 1'b0;
        mem_op_o   = MEM_RD;
        bo_arm_o   = 1'b0;
        bo_clear_o = 1'b0;
        unique case (state_q)
            ST_POLL:     mem_req_o = 1'b1;
            ST_TAS: begin
                mem_req_o = 1'b1;
                mem_op_o  = MEM_TAS;
            end
            ST_TAS_WAIT: begin
                bo_arm_o   = mem_rvalid_i && rd_nonzero_i;
                bo_clear_o = mem_rvalid_i && !rd_nonzero_i;
            end
            ST_RELEASE: begin
                mem_req_o = 1'b1;
                mem_op_o  = MEM_WR;
            end
            default: ;
        endcase
    end

    assign granted_o = grant_q;
    assign holding_o = (state_q == ST_HELD);

    p_req_stable_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_op_o)));

    p_grant_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        granted_o |=> !granted_o);

    p_win_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAS_WAIT && mem_rvalid_i && !rd_nonzero_i) |=> (granted_o && holding_o));

    p_fail_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TAS_WAIT && mem_rvalid_i && rd_nonzero_i) |=> !mem_req_o);

    p_release_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (holding_o && rel_cmd_i) |=> (mem_req_o && mem_op_o == MEM_WR && !holding_o));

    p_zero_read_tas_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL_WAIT && mem_rvalid_i && !rd_nonzero_i) |=> (mem_req_o && mem_op_o == MEM_TAS));

endmodule

// File: rtl/tas_lock_requester.sv
module tas_lock_requester #(
    parameter int DATA_W      = 8,
    parameter int MAX_BACKOFF = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acq_cmd,
    input  logic              rel_cmd,
    output logic              granted,
    output logic              holding,
    output logic              mem_req,
    output logic [1:0]        mem_op,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_gnt,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata
);

    import tasl_pkg::*;

    mem_op_e op_w;
    logic    bo_arm, bo_clear, bo_expire;
    logic    rd_nonzero;

    assign rd_nonzero = |mem_rdata;

    tasl_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .acq_cmd_i    (acq_cmd),
        .rel_cmd_i    (rel_cmd),
        .mem_gnt_i    (mem_gnt),
        .mem_rvalid_i (mem_rvalid),
        .rd_nonzero_i (rd_nonzero),
        .bo_expire_i  (bo_expire),
        .mem_req_o    (mem_req),
        .mem_op_o     (op_w),
        .bo_arm_o     (bo_arm),
        .bo_clear_o   (bo_clear),
        .granted_o    (granted),
        .holding_o    (holding)
    );

    tasl_backoff #(.MAX_BACKOFF(MAX_BACKOFF)) u_backoff (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_i    (bo_arm),
        .clear_i  (bo_clear),
        .expire_o (bo_expire)
    );

    assign mem_op    = op_w;
    assign mem_wdata = '0;

endmodule

// File: tb/tas_lock_requester_test.sv
`timescale 1ns/100ps
module tas_lock_requester_test;

    localparam int N    = 3;
    localparam int DW   = 4;
    localparam int MAXB = 8;
    localparam int K    = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [N-1:0] acq = '0, rel = '0;
    logic [N-1:0] req, gnt, held, grt;
    logic [N-1:0] rv;
    logic [1:0]    op [N];
    logic [DW-1:0] wd [N];
    logic [1:0]    rkind [N];
    logic [DW-1:0] rdat;

    for (genvar g = 0; g < N; g++) begin : g_req
        tas_lock_requester #(.DATA_W(DW), .MAX_BACKOFF(MAXB)) uut (
            .clk(clk), .rst_n(rst_n), .acq_cmd(acq[g]), .rel_cmd(rel[g]),
            .granted(grt[g]), .holding(held[g]), .mem_req(req[g]), .mem_op(op[g]),
            .mem_wdata(wd[g]), .mem_gnt(gnt[g]), .mem_rvalid(rv[g]), .mem_rdata(rdat)
        );
    end

    // shared lock word, round-robin arbiter, forced test-and-set failures
    int   rr = 0, used = 0, budget = 0;
    logic lock_mem;
    logic ctl_set = 1'b0, ctl_val = 1'b0;
    int   cyc = 0;

    always_comb begin
        gnt = '0;
        for (int k = 0; k < N; k++) begin
            int idx;
            idx = (rr + k) % N;
            if (req[idx] && gnt == '0) gnt[idx] = 1'b1;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (!rst_n) begin
            lock_mem <= 1'b0; rv <= '0; rr <= 0; used <= 0; rdat <= '0;
            for (int k = 0; k < N; k++) rkind[k] <= 2'b00;
        end else begin
            rv <= '0;
            if (ctl_set) lock_mem <= ctl_val;
            for (int k = 0; k < N; k++) begin
                if (gnt[k]) begin
                    rr <= (k + 1) % N;
                    rkind[k] <= op[k];
                    case (op[k])
                        2'b00: begin rv[k] <= 1'b1; rdat <= DW'(lock_mem); end
                        2'b10: begin
                            rv[k] <= 1'b1;
                            if (used < budget) begin
                                rdat <= DW'(1); used <= used + 1;
                            end else begin
                                rdat <= DW'(lock_mem); lock_mem <= 1'b1;
                            end
                        end
                        2'b01: lock_mem <= (wd[k] != '0);
                        default: ;
                    endcase
                end
            end
        end
    end

    // monitor, sampled at the falling edge
    int reads0 = 0, tas0 = 0, wr0 = 0, excl = 0, gap_n = 0, fail_t = 0;
    int gap_v [32];
    int gcnt [N];
    bit pend = 0;
    initial for (int k = 0; k < N; k++) gcnt[k] = 0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (req[0] && gnt[0]) begin
                if (op[0] == 2'b00) reads0++;
                if (op[0] == 2'b10) tas0++;
                if (op[0] == 2'b01) wr0++;
            end
            if (rv[0] && rkind[0] == 2'b10 && rdat != '0) begin
                pend = 1; fail_t = cyc;
            end
            if (req[0] && gnt[0] && op[0] == 2'b00 && pend) begin
                if (gap_n < 32) gap_v[gap_n] = cyc - fail_t;
                gap_n++; pend = 0;
            end
            if ($countones(held) > 1) excl++;
            for (int k = 0; k < N; k++) if (grt[k]) gcnt[k]++;
        end
    end

    int checks = 0, errors = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk); #1;
    endtask

    task automatic pulse_acq(input int id);
        acq[id] = 1'b1; tick(); acq[id] = 1'b0;
    endtask

    task automatic pulse_rel(input int id);
        rel[id] = 1'b1; tick(); rel[id] = 1'b0;
    endtask

    task automatic set_lock(input logic v);
        ctl_val = v; ctl_set = 1'b1; tick(); ctl_set = 1'b0;
    endtask

    task automatic wait_grant(input int id);
        while (!grt[id]) tick();
    endtask

    task automatic worker(input int id);
        for (int r = 0; r < K; r++) begin
            pulse_acq(id);
            wait_grant(id);
            repeat (3) tick();
            pulse_rel(id);
            while (held[id] || req[id]) tick();
        end
    endtask

    initial begin
        int r0, t0, w0, gb;
        repeat (4) tick();
        check(req == '0,  "R1 mem_req after reset", int'(req), 0);
        check(held == '0, "R1 holding after reset", int'(held), 0);
        check(grt == '0,  "R1 granted after reset", int'(grt), 0);
        rst_n = 1'b1;
        tick();

        // R10: release while idle does nothing
        r0 = reads0; w0 = wr0;
        pulse_rel(0);
        repeat (5) tick();
        check(reads0 + wr0 == r0 + w0, "R10 idle release requests", reads0 + wr0, r0 + w0);
        check(held[0] == 1'b0, "R10 idle release holding", int'(held[0]), 0);

        // R2/R3: lock taken -> reads only
        set_lock(1'b1);
        r0 = reads0; t0 = tas0;
        pulse_acq(0);
        repeat (30) tick();
        check(reads0 >= r0 + 5, "R2 reads issued after acquire", reads0 - r0, 5);
        check(tas0 == t0, "R3 no test-and-set while busy", tas0 - t0, 0);

        // R4/R5: lock freed -> one TAS and grant
        set_lock(1'b0);
        wait_grant(0);
        check(tas0 == t0 + 1, "R4 single test-and-set", tas0 - t0, 1);
        check(held[0] == 1'b1, "R5 holding with grant", int'(held[0]), 1);
        tick();
        check(grt[0] == 1'b0, "R5 grant pulse one cycle", int'(grt[0]), 0);
        check(lock_mem == 1'b1, "R5 lock word set", int'(lock_mem), 1);

        // R10: acquire while holding does nothing
        r0 = reads0; t0 = tas0;
        pulse_acq(0);
        repeat (5) tick();
        check(reads0 + tas0 == r0 + t0, "R10 acquire while holding", reads0 + tas0, r0 + t0);

        // R9: release
        w0 = wr0;
        pulse_rel(0);
        repeat (4) tick();
        check(held[0] == 1'b0, "R9 holding dropped", int'(held[0]), 0);
        check(wr0 == w0 + 1, "R9 one write", wr0 - w0, 1);
        check(lock_mem == 1'b0, "R9 lock word cleared", int'(lock_mem), 0);

        // R6/R7: six forced failures, gap = interval + 1
        gb = gap_n;
        budget = used + 6;
        pulse_acq(0);
        wait_grant(0);
        check(gap_n - gb == 6, "R7 failure count", gap_n - gb, 6);
        for (int j = 0; j < 6; j++) begin
            int bexp;
            bexp = ((1 << j) > MAXB) ? MAXB : (1 << j);
            check(gap_v[gb + j] == bexp + 1, j < 3 ? "R6 backoff gap" : "R7 saturated gap",
                  gap_v[gb + j], bexp + 1);
        end
        pulse_rel(0);
        repeat (4) tick();

        // R8: interval back to 1 after success
        gb = gap_n;
        budget = used + 1;
        pulse_acq(0);
        wait_grant(0);
        check(gap_n - gb == 1 && gap_v[gb] == 2, "R8 interval reset", gap_v[gb], 2);
        pulse_rel(0);
        repeat (4) tick();

        // R12: contention among all requesters
        begin
            int g0 [N];
            for (int k = 0; k < N; k++) g0[k] = gcnt[k];
            for (int i = 0; i < N; i++) begin
                fork
                    automatic int id = i;
                    worker(id);
                join_none
            end
            wait fork;
            repeat (4) tick();
            for (int k = 0; k < N; k++)
                check(gcnt[k] - g0[k] == K, "R12 every acquire granted", gcnt[k] - g0[k], K);
        end
        check(excl == 0, "R12 mutual exclusion", excl, 0);
        check(lock_mem == 1'b0, "R12 lock free at end", int'(lock_mem), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R12 watchdog: actual %0d expected %0d", 100000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule